// File: doc/BRIEF.md
# Instruction Fetch Control Sequencer

This block is the control state machine that fetches one instruction in a small 16-bit processor built around a shared internal bus. The datapath it steers has four registers: the program counter, the memory address register, the memory data register and the instruction register. Each register has a load enable. The program counter and the memory data register can also be gated onto the bus. The sequencer only issues strobes. It holds no data and sees nothing of the datapath.

A fetch begins when the start/continue request is seen while the sequencer is idle. It then runs five bus steps in a fixed order:

1. The program counter goes to the memory address register.
2. A memory read is issued.
3. The read word is captured in the memory data register. This step stalls while memory is not ready.
4. The captured word moves to the instruction register, and the program counter advances by one.
5. A quiet cycle.

After step 5 the block raises a one-cycle hand-off pulse to the decode stage and returns to idle. Only one bus source is gated in any cycle, so the bus never has two drivers.

Top module: `fetch_seq`

## Requirements
- R1: While reset is low, every strobe and the decode pulse are low, and the mux select reads the hold code 2'b11. After reset the block is idle with the same outputs. It leaves idle only on a clock edge where the start request is high.
- R2: Step 1 follows the idle cycle in which the start request was sampled high. In step 1 only the PC gate and the MAR load are high.
- R3: Step 2 follows step 1. In step 2 only the read/write line (1 = read) and the memory enable are high.
- R4: In step 3 with memory ready high, the MDR load and the read/write line are high, and the memory enable is low.
- R5: In step 3 with memory ready low, the block stays in step 3. The memory enable and the read/write line stay high and the MDR load stays low, until memory ready is seen high.
- R6: Step 4 follows step 3 with ready. In step 4 the MDR gate, the IR load and the PC load are high, and the PC mux select is 2'b00 (PC+1). Outside step 4 the select is 2'b11.
- R7: Step 5 follows step 4, with every strobe low.
- R8: The decode pulse is high for exactly the one cycle after step 5. The block is idle on the next cycle.
- R9: The PC gate and the MDR gate are never high in the same cycle.
- R10: The start request has no effect outside the idle state.
- R11: In a datapath steered by these strobes, each fetch leaves the memory word at the old PC in the instruction register, and the PC one higher, modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| go_i | input | 1 | Start/continue request, sampled in idle |
| mem_rdy_i | input | 1 | Memory ready for the read in step 3 |
| pc_gate_o | output | 1 | Drive program counter onto the bus |
| mar_ld_o | output | 1 | Load memory address register from the bus |
| mdr_ld_o | output | 1 | Load memory data register from memory |
| mdr_gate_o | output | 1 | Drive memory data register onto the bus |
| ir_ld_o | output | 1 | Load instruction register from the bus |
| pc_ld_o | output | 1 | Load program counter from its mux |
| pc_sel_o | output | 2 | PC mux select: 00 = PC+1, 11 = hold code |
| rd_wr_o | output | 1 | Memory direction, 1 = read |
| mem_en_o | output | 1 | Memory access enable |
| decode_o | output | 1 | One-cycle hand-off to decode |

## Verification
The hardest case to reach is a long memory stall in step 3. It matters because the outputs there depend on the ready input within the same cycle. The bench changes ready at the falling edge and samples the strobes just after. It also inserts random runs of not-ready cycles before ready rises, so both the held-enable state and the capture state are observed from one state.

Two other cases are forced directly: a reset that lands in step 4, and a start of fetch from a program counter near 16'hFFFF, which checks the wrap.

Throughout, the start request is toggled at random inside the sequence. This shows it is ignored outside idle.

// File: rtl/fetch_seq_pkg.sv
`timescale 1ns/1ps
package fetch_seq_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned SEL_W  = 2;
  localparam logic [SEL_W-1:0] SEL_INC  = 2'b00;
  localparam logic [SEL_W-1:0] SEL_HOLD = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADR  = 3'd1,
    ST_RD   = 3'd2,
    ST_CAP  = 3'd3,
    ST_XFER = 3'd4,
    ST_END  = 3'd5,
    ST_DEC  = 3'd6
  } fetch_st_e;

  typedef struct packed {
    logic             pc_gate;
    logic             mar_ld;
    logic             mdr_ld;
    logic             mdr_gate;
    logic             ir_ld;
    logic             pc_ld;
    logic [SEL_W-1:0] pc_sel;
    logic             rd_wr;
    logic             mem_en;
    logic             decode;
  } strobe_t;
endpackage

// File: rtl/fetch_seq_ctl.sv
`timescale 1ns/1ps
module fetch_seq_ctl
  import fetch_seq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      go_i,
  input  logic      mem_rdy_i,
  output fetch_st_e st_o
);
  fetch_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (go_i) st_d = ST_ADR;
      ST_ADR:  st_d = ST_RD;
      ST_RD:   st_d = ST_CAP;
      ST_CAP:  if (mem_rdy_i) st_d = ST_XFER;  // stall until memory answers
      ST_XFER: st_d = ST_END;
      ST_END:  st_d = ST_DEC;
      ST_DEC:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign st_o = st_q;
endmodule

// File: rtl/fetch_seq_dec.sv
`timescale 1ns/1ps
module fetch_seq_dec
  import fetch_seq_pkg::*;
(
  input  fetch_st_e st_i,
  input  logic      mem_rdy_i,
  output strobe_t   stb_o
);
  always_comb begin
    stb_o        = '0;
    stb_o.pc_sel = SEL_HOLD;
    unique case (st_i)
      ST_ADR: begin
        stb_o.pc_gate = 1'b1;
        stb_o.mar_ld  = 1'b1;
      end
      ST_RD: begin
        stb_o.rd_wr  = 1'b1;
        stb_o.mem_en = 1'b1;
      end
      ST_CAP: begin
        stb_o.rd_wr  = 1'b1;
        // enable held through a stall, capture once ready
        stb_o.mem_en = !mem_rdy_i;
        stb_o.mdr_ld = mem_rdy_i;
      end
      ST_XFER: begin
        stb_o.mdr_gate = 1'b1;
        stb_o.ir_ld    = 1'b1;
        stb_o.pc_ld    = 1'b1;
        stb_o.pc_sel   = SEL_INC;
      end
      ST_DEC:  stb_o.decode = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/fetch_seq.sv
`timescale 1ns/1ps
module fetch_seq
  import fetch_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic             mem_rdy_i,
  output logic             pc_gate_o,
  output logic             mar_ld_o,
  output logic             mdr_ld_o,
  output logic             mdr_gate_o,
  output logic             ir_ld_o,
  output logic             pc_ld_o,
  output logic [SEL_W-1:0] pc_sel_o,
  output logic             rd_wr_o,
  output logic             mem_en_o,
  output logic             decode_o
);
  fetch_st_e st;
  strobe_t   stb;

  fetch_seq_ctl u_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .go_i      (go_i),
    .mem_rdy_i (mem_rdy_i),
    .st_o      (st)
  );

  fetch_seq_dec u_dec (
    .st_i      (st),
    .mem_rdy_i (mem_rdy_i),
    .stb_o     (stb)
  );

  assign pc_gate_o  = stb.pc_gate;
  assign mar_ld_o   = stb.mar_ld;
  assign mdr_ld_o   = stb.mdr_ld;
  assign mdr_gate_o = stb.mdr_gate;
  assign ir_ld_o    = stb.ir_ld;
  assign pc_ld_o    = stb.pc_ld;
  assign pc_sel_o   = stb.pc_sel;
  assign rd_wr_o    = stb.rd_wr;
  assign mem_en_o   = stb.mem_en;
  assign decode_o   = stb.decode;
endmodule

// File: rtl/fetch_seq_chk.sv
`timescale 1ns/1ps
module fetch_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mem_rdy_i,
  input logic       pc_gate_o,
  input logic       mar_ld_o,
  input logic       mdr_ld_o,
  input logic       mdr_gate_o,
  input logic       ir_ld_o,
  input logic       pc_ld_o,
  input logic [1:0] pc_sel_o,
  input logic       rd_wr_o,
  input logic       mem_en_o,
  input logic       decode_o
);
  // R9
  one_driver_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pc_gate_o, mdr_gate_o}));

  // R3
  rd_after_adr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mar_ld_o |=> (mem_en_o && rd_wr_o && !mar_ld_o && !pc_gate_o));

  // R5
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_en_o && !mem_rdy_i) |=> (rd_wr_o && (mem_en_o || mdr_ld_o)));

  // R6
  xfer_after_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdr_ld_o |=> (mdr_gate_o && ir_ld_o && pc_ld_o && pc_sel_o == 2'b00));

  // R7
  quiet_after_xfer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_ld_o |=> !(pc_gate_o || mar_ld_o || mdr_ld_o || mdr_gate_o || ir_ld_o ||
                  pc_ld_o || rd_wr_o || mem_en_o || decode_o));

  // R8
  decode_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decode_o |=> !decode_o);

  // R8
  decode_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decode_o |-> $past(ir_ld_o, 2));
endmodule

bind fetch_seq fetch_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_rdy_i  (mem_rdy_i),
  .pc_gate_o  (pc_gate_o),
  .mar_ld_o   (mar_ld_o),
  .mdr_ld_o   (mdr_ld_o),
  .mdr_gate_o (mdr_gate_o),
  .ir_ld_o    (ir_ld_o),
  .pc_ld_o    (pc_ld_o),
  .pc_sel_o   (pc_sel_o),
  .rd_wr_o    (rd_wr_o),
  .mem_en_o   (mem_en_o),
  .decode_o   (decode_o)
);

// File: tb/tb_fetch_seq.sv
`timescale 1ns/1ps
module tb_fetch_seq;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic go = 1'b0;
  logic rdy = 1'b1;
  logic pc_gate, mar_ld, mdr_ld, mdr_gate, ir_ld, pc_ld, rd_wr, mem_en, decode;
  logic [1:0] pc_sel;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fetch_seq dut (
    .clk_i(clk), .rst_ni(rst_ni), .go_i(go), .mem_rdy_i(rdy),
    .pc_gate_o(pc_gate), .mar_ld_o(mar_ld), .mdr_ld_o(mdr_ld),
    .mdr_gate_o(mdr_gate), .ir_ld_o(ir_ld), .pc_ld_o(pc_ld),
    .pc_sel_o(pc_sel), .rd_wr_o(rd_wr), .mem_en_o(mem_en), .decode_o(decode)
  );

  // datapath model
  logic [15:0] m_pc = 16'hFFFD;
  logic [15:0] m_mar = '0, m_mdr = '0, m_ir = '0;
  logic [15:0] bus;

  function automatic logic [15:0] mem_word(input logic [15:0] a);
    return (a * 16'h9E37) ^ 16'h5A5A ^ {a[7:0], a[15:8]};
  endfunction

  assign bus = pc_gate ? m_pc : (mdr_gate ? m_mdr : 16'h0000);

  always @(posedge clk) begin
    if (mar_ld) m_mar <= bus;
    if (mdr_ld) m_mdr <= mem_word(m_mar);
    if (ir_ld)  m_ir  <= bus;
    if (pc_ld && pc_sel == 2'b00) m_pc <= m_pc + 16'd1;
  end

  // {pc_gate,mar_ld,mdr_ld,mdr_gate,ir_ld,pc_ld,rd_wr,mem_en,decode,sel}
  function automatic logic [10:0] exp_vec(input int step, input bit r);
    case (step)
      1: return 11'b1100_0000_0_11;
      2: return 11'b0000_0011_0_11;
      3: return r ? 11'b0010_0010_0_11 : 11'b0000_0011_0_11;
      4: return 11'b0001_1100_0_00;
      6: return 11'b0000_0000_1_11;
      default: return 11'b0000_0000_0_11;
    endcase
  endfunction

  function automatic logic [10:0] act_vec();
    return {pc_gate, mar_ld, mdr_ld, mdr_gate, ir_ld, pc_ld, rd_wr, mem_en, decode, pc_sel};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_vec(input string req, input int step, input bit r);
    chk(req, {5'd0, act_vec()}, {5'd0, exp_vec(step, r)});
  endtask

  task automatic fetch_once(input int stalls);
    logic [15:0] pc0;
    pc0 = m_pc;
    @(negedge clk); go = 1'b1; #1 chk_vec("R1 idle", 0, 1'b1);
    @(negedge clk); go = 1'($urandom); #1 chk_vec("R2 step1", 1, 1'b1);
    @(negedge clk); go = 1'($urandom); rdy = 1'($urandom); #1 chk_vec("R3 step2 R10", 2, 1'b1);
    for (int i = 0; i < stalls; i++) begin
      @(negedge clk); rdy = 1'b0; go = 1'($urandom); #1 chk_vec("R5 stall", 3, 1'b0);
    end
    @(negedge clk); rdy = 1'b1; #1 chk_vec("R4 capture", 3, 1'b1);
    @(negedge clk); go = 1'($urandom); rdy = 1'($urandom); #1 chk_vec("R6 transfer", 4, 1'b1);
    @(negedge clk); go = 1'($urandom); #1 chk_vec("R7 quiet", 5, 1'b1);
    @(negedge clk); go = 1'($urandom); #1 chk_vec("R8 decode", 6, 1'b1);
    @(negedge clk); go = 1'b0; #1 chk_vec("R8 back to idle", 0, 1'b1);
    chk("R11 ir", m_ir, mem_word(pc0));
    chk("R11 pc", m_pc, pc0 + 16'd1);
  endtask

  task automatic reset_mid();
    logic [15:0] pc0;
    pc0 = m_pc;
    @(negedge clk); go = 1'b1;
    @(negedge clk); go = 1'b0;
    @(negedge clk); rdy = 1'b1;
    @(negedge clk);
    @(negedge clk); #1 chk_vec("R6 before reset", 4, 1'b1);
    rst_ni = 1'b0; #1 chk_vec("R1 in reset", 0, 1'b1);
    repeat (2) @(negedge clk);
    #1 chk_vec("R1 held reset", 0, 1'b1);
    rst_ni = 1'b1;
    repeat (3) begin
      @(negedge clk); #1 chk_vec("R1 idle after reset", 0, 1'b1);
    end
    chk("R1 no load in reset", m_pc, pc0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    #1 chk_vec("R1 reset out", 0, 1'b1);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) begin
      @(negedge clk); #1 chk_vec("R1 wait for go", 0, 1'b1);
    end
    // directed: PC wrap, zero/one/long stall
    fetch_once(0);
    fetch_once(1);
    fetch_once(0);
    chk("R11 wrap", m_pc, 16'h0000);
    fetch_once(7);
    reset_mid();
    fetch_once(2);
    for (int k = 0; k < 40; k++) begin
      int gap;
      gap = int'($urandom % 3);
      for (int g = 0; g < gap; g++) begin
        @(negedge clk); go = 1'b0; rdy = 1'($urandom); #1 chk_vec("R1 idle gap", 0, 1'b1);
      end
      fetch_once(int'($urandom % 4));
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule